// File: doc/BRIEF.md
# Serial Switch Control Register

This block is a write-mostly serial slave that owns an eight-line switch-enable word. A host holds the active-low frame input low and clocks data in on the serial data input, one bit on each falling edge of the serial clock. When the frame input returns high, the collected word is moved to the switch-enable outputs. A 1 closes a switch and a 0 opens it, and any mix of lines may be closed together. The serial data output repeats, on each rising serial-clock edge, the bit that is about to leave the input register. Several blocks that share the frame and clock lines can therefore be chained by wiring each serial data output to the next block's serial data input.

The transfer to the outputs never shorts two paths. Lines that go from closed to open drop at once. Lines that go from open to closed wait for a gap of `GAP_CYC` system clocks. Lines that are closed in both the old and the new word stay closed the whole time. A busy flag covers the whole sequence. An active-low clear input empties the input register and opens every switch.

All serial inputs are asynchronous. They pass through a two-flop synchronizer on the system clock, and edges are found by comparing against a registered copy. The high and low phases of the serial clock must each last at least three system clocks, so that a chained neighbour sees stable data.

Top module: `serial_switch_ctrl`

## Requirements
- R1: While `frame_n` is low, each falling `sclk` edge shifts `sdi` into bit 0 of the input register and moves the older bits up by one. The first bit of an eight-bit write therefore ends in bit 7.
- R2: Bit i of the transferred word drives `sw_en[i]`, with 1 meaning closed. Every one of the 256 patterns is accepted as is.
- R3: A write may have any number of clocks. After more than eight, only the last eight bits remain. After fewer, the older contents sit above the new bits.
- R4: On each rising `sclk` edge while `frame_n` is low, `sdo` takes the value of bit 7 of the input register. In a chain, a second block therefore receives the first block's earlier contents, followed by the leading bits of the current write.
- R5: `sw_en` changes only as the result of a rising edge of `frame_n` (or a clear). Bits shifted in during a frame have no effect on `sw_en` before that edge.
- R6: While `frame_n` is high, `sclk` and `sdi` have no effect on the input register or on `sdo`.
- R7: While the system reset `rst_n` is low, or the synchronized `clr_n` is low, the input register, `sdo`, `sw_en` and `busy` are all 0.
- R8: The first output change after a transfer starts opens the lines that turn off. Lines that turn on close exactly `GAP_CYC` clocks later. Lines that are on in both words never open.
- R9: `busy` rises on the third clock edge after `frame_n` rises at the pin. With no overlapping transfer, it falls on the same edge that applies the new word.
- R10: If `frame_n` rises again while a transfer is running, that transfer finishes with its own word. The newer word then runs its own break-before-make sequence, and `busy` stays high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| clr_n | input | 1 | Asynchronous active-low clear of register and switches |
| frame_n | input | 1 | Active-low frame; a rising edge transfers the word |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data in, first bit lands in the MSB |
| sdo | output | 1 | Serial data out for chaining, updated on rising sclk |
| sw_en | output | NSW | Switch-enable lines, 1 = closed |
| busy | output | 1 | High while a transfer sequence is pending or running |

## Verification
Every pin change reaches the logic after the two synchronizer flops. The block acts on the third rising clock edge after the change. A frame rise therefore shows up as `busy` and the opening lines on that third edge, and the closing lines appear `GAP_CYC` edges later. The bench drives pins on falling clock edges and advances its reference model on the rising edges. It compares `sw_en`, `sdo` and `busy` of both chained instances with that model on every falling edge. Directed checks count the falling edges after a frame rise, which pins down the edge on which `busy` rises and the edge on which the closing lines appear. They also hold the lines that stay closed under watch for every cycle of an update.

// File: rtl/serial_switch_ctrl_pkg.sv
// Shared types for the serial switch control register.
package serial_switch_ctrl_pkg;

    // Transfer sequencer phase: waiting, or holding the break gap.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_GAP  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/ssc_sync.sv
// Two-flop synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes: each lane toggles slowly against clk; per-lane reset value given.
module ssc_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level
);

    for (genvar g = 0; g < W; g++) begin : g_lane
        logic meta, stable;

        // Two-stage capture of one asynchronous lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta   <= RST_VAL[g];
                stable <= RST_VAL[g];
            end else begin
                meta   <= async_in[g];
                stable <= meta;
            end
        end

        assign level[g] = stable;
    end

endmodule

// File: rtl/ssc_shift.sv
// Serial input register with chain output.
// Assumes: edge strobes are single-cycle and sck_rise/sck_fall never coincide.
module ssc_shift #(
    parameter int NSW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           frame_low,
    input  logic           sck_rise,
    input  logic           sck_fall,
    input  logic           sdi_s,
    output logic [NSW-1:0] word,
    output logic           sdo
);

    // Shift on falling serial edges, present the MSB on rising ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word <= '0;
            sdo  <= 1'b0;
        end else if (frame_low) begin
            if (sck_fall) word <= {word[NSW-2:0], sdi_s};
            if (sck_rise) sdo  <= word[NSW-1];
        end
    end

endmodule

// File: rtl/ssc_bbm.sv
// Break-before-make sequencer driving the switch-enable lines.
// Assumes: GAP_CYC >= 1; start is a single-cycle strobe with new_word valid.
module ssc_bbm
    import serial_switch_ctrl_pkg::*;
#(
    parameter int NSW     = 8,
    parameter int GAP_CYC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           start,
    input  logic [NSW-1:0] new_word,
    output logic [NSW-1:0] sw_en,
    output logic           busy
);

    localparam int CW = $clog2(GAP_CYC + 1);

    seq_state_e      state;
    logic [CW-1:0]   cnt;
    logic [NSW-1:0]  target;
    logic [NSW-1:0]  held_word;
    logic            held_valid;

    // Open leaving lines, wait the gap, then close arriving lines.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state      <= SEQ_IDLE;
            cnt        <= '0;
            target     <= '0;
            held_word  <= '0;
            held_valid <= 1'b0;
            sw_en      <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (held_valid) begin
                        sw_en      <= sw_en & held_word;
                        target     <= held_word;
                        cnt        <= CW'(GAP_CYC);
                        state      <= SEQ_GAP;
                        held_valid <= start;
                        if (start) held_word <= new_word;
                    end else if (start) begin
                        sw_en  <= sw_en & new_word;
                        target <= new_word;
                        cnt    <= CW'(GAP_CYC);
                        state  <= SEQ_GAP;
                    end
                end
                default: begin
                    if (start) begin
                        held_valid <= 1'b1;
                        held_word  <= new_word;
                    end
                    if (cnt == CW'(1)) begin
                        sw_en <= target;
                        state <= SEQ_IDLE;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
            endcase
        end
    end

    assign busy = (state == SEQ_GAP) || held_valid;

endmodule

// File: rtl/serial_switch_ctrl.sv
// Serial switch control register: synchronizes the serial pins, shifts
// the word in, and hands it to the break-before-make sequencer on the
// rising edge of frame_n.
// Assumes: sclk high and low phases each last at least three clk cycles.
module serial_switch_ctrl #(
    parameter int NSW     = 8,
    parameter int GAP_CYC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_n,
    input  logic           frame_n,
    input  logic           sclk,
    input  logic           sdi,
    output logic           sdo,
    output logic [NSW-1:0] sw_en,
    output logic           busy
);

    localparam int NPIN = 4;
    localparam logic [NPIN-1:0] PIN_IDLE = 4'b1100;

    logic [NPIN-1:0] pin_s;
    logic            frame_prev, sclk_prev;
    logic            clr_s, frame_hi_s, frame_rise_s;
    logic            sck_rise_s, sck_fall_s;
    logic [NSW-1:0]  shift_word;

    ssc_sync #(.W(NPIN), .RST_VAL(PIN_IDLE)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({clr_n, frame_n, sclk, sdi}),
        .level    (pin_s)
    );

    // Registered copies of frame and serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_prev <= 1'b1;
            sclk_prev  <= 1'b0;
        end else begin
            frame_prev <= pin_s[2];
            sclk_prev  <= pin_s[1];
        end
    end

    assign clr_s        = ~pin_s[3];
    assign frame_hi_s   = pin_s[2];
    assign frame_rise_s = pin_s[2] & ~frame_prev;
    assign sck_rise_s   = pin_s[1] & ~sclk_prev;
    assign sck_fall_s   = ~pin_s[1] & sclk_prev;

    ssc_shift #(.NSW(NSW)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_s),
        .frame_low (~frame_hi_s),
        .sck_rise  (sck_rise_s),
        .sck_fall  (sck_fall_s),
        .sdi_s     (pin_s[0]),
        .word      (shift_word),
        .sdo       (sdo)
    );

    ssc_bbm #(.NSW(NSW), .GAP_CYC(GAP_CYC)) i_bbm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_s),
        .start    (frame_rise_s),
        .new_word (shift_word),
        .sw_en    (sw_en),
        .busy     (busy)
    );

endmodule

// File: rtl/serial_switch_ctrl_chk.sv
// Property checker for serial_switch_ctrl, attached through bind.
// Assumes: GAP_CYC >= 1; the gap is measured with a saturating counter.
module serial_switch_ctrl_chk #(
    parameter int NSW     = 8,
    parameter int GAP_CYC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_s,
    input  logic           frame_hi_s,
    input  logic           frame_rise_s,
    input  logic           sdo,
    input  logic [NSW-1:0] sw_en,
    input  logic           busy
);

    localparam int AW = $clog2(GAP_CYC + 1) + 1;

    logic [NSW-1:0] prev_sw;
    logic [NSW-1:0] fell_now, rose_now;
    logic [AW-1:0]  age;

    assign fell_now = prev_sw & ~sw_en;
    assign rose_now = ~prev_sw & sw_en;

    // Clocks since the last line opened, saturating at the gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sw <= '0;
            age     <= AW'(GAP_CYC);
        end else begin
            prev_sw <= sw_en;
            if (|fell_now)                age <= AW'(1);
            else if (age < AW'(GAP_CYC))  age <= age + AW'(1);
        end
    end

    a_r8_gap_before_close: assert property (@(posedge clk) disable iff (!rst_n)
        (|rose_now) |-> (!(|fell_now) && age >= AW'(GAP_CYC)));

    a_r5_change_only_in_update: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en != $past(sw_en)) |-> (busy || $past(busy) || $past(clr_s)));

    a_r7_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        clr_s |=> (sw_en == '0 && !busy && !sdo));

    a_r9_busy_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_rise_s && !clr_s) |=> busy);

    a_r6_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_hi_s && !clr_s) |=> $stable(sdo));

endmodule

bind serial_switch_ctrl serial_switch_ctrl_chk #(.NSW(NSW), .GAP_CYC(GAP_CYC)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_s        (clr_s),
    .frame_hi_s   (frame_hi_s),
    .frame_rise_s (frame_rise_s),
    .sdo          (sdo),
    .sw_en        (sw_en),
    .busy         (busy)
);

// File: tb/test_serial_switch_ctrl.sv
`timescale 1ns/1ps
module test_serial_switch_ctrl;

    localparam int GAP = 24;
    localparam int H   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, clr_n = 1'b1, frame_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic       sdo0, sdo1, busy0, busy1;
    logic [7:0] sw0, sw1;
    int checks = 0, errors = 0;
    bit started = 1'b0, done = 1'b0;

    always #10 clk = ~clk;

    serial_switch_ctrl #(.NSW(8), .GAP_CYC(GAP)) i_serial_switch_ctrl (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .frame_n(frame_n),
        .sclk(sclk), .sdi(sdi), .sdo(sdo0), .sw_en(sw0), .busy(busy0));

    serial_switch_ctrl #(.NSW(8), .GAP_CYC(GAP)) i_serial_switch_ctrl_chain (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .frame_n(frame_n),
        .sclk(sclk), .sdi(sdo0), .sdo(sdo1), .sw_en(sw1), .busy(busy1));

    // ---------------- reference model (one slot per chained device) ----
    logic [2:0] mf [2], mk [2], md [2], mc [2];
    logic [7:0] msr [2], msw [2], mtg [2], mpw [2];
    logic       mdo [2], mpd [2], mact [2];
    int         mcnt [2];

    task automatic mstep(input int d, input logic fr, input logic ck,
                         input logic di, input logic cl);
        logic frise, flow, krise, kfall;
        if (!rst_n) begin
            mf[d] = 3'b111; mk[d] = 3'b000; md[d] = 3'b000; mc[d] = 3'b111;
            msr[d] = 8'h00; msw[d] = 8'h00; mtg[d] = 8'h00; mpw[d] = 8'h00;
            mdo[d] = 1'b0; mpd[d] = 1'b0; mact[d] = 1'b0; mcnt[d] = 0;
            return;
        end
        frise = mf[d][1] && !mf[d][2];
        flow  = !mf[d][1];
        krise = mk[d][1] && !mk[d][2];
        kfall = !mk[d][1] && mk[d][2];
        if (!mc[d][1]) begin
            msr[d] = 8'h00; msw[d] = 8'h00; mtg[d] = 8'h00; mpw[d] = 8'h00;
            mdo[d] = 1'b0; mpd[d] = 1'b0; mact[d] = 1'b0; mcnt[d] = 0;
        end else begin
            if (flow && krise) mdo[d] = msr[d][7];
            if (flow && kfall) msr[d] = {msr[d][6:0], md[d][1]};
            if (!mact[d]) begin
                if (mpd[d]) begin
                    msw[d] = msw[d] & mpw[d]; mtg[d] = mpw[d];
                    mcnt[d] = GAP; mact[d] = 1'b1; mpd[d] = frise;
                    if (frise) mpw[d] = msr[d];
                end else if (frise) begin
                    msw[d] = msw[d] & msr[d]; mtg[d] = msr[d];
                    mcnt[d] = GAP; mact[d] = 1'b1;
                end
            end else begin
                if (frise) begin mpd[d] = 1'b1; mpw[d] = msr[d]; end
                if (mcnt[d] == 1) begin msw[d] = mtg[d]; mact[d] = 1'b0; end
                else mcnt[d] = mcnt[d] - 1;
            end
        end
        mf[d] = {mf[d][1:0], fr};
        mk[d] = {mk[d][1:0], ck};
        md[d] = {md[d][1:0], di};
        mc[d] = {mc[d][1:0], cl};
    endtask

    // Advance the model on every rising edge with the pin values.
    always @(posedge clk) begin
        logic chain_in;
        chain_in = mdo[0];
        mstep(0, frame_n, sclk, sdi, clr_n);
        mstep(1, frame_n, sclk, chain_in, clr_n);
        started <= 1'b1;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output of both devices on each falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check("R2/R8 model sw dev0", {8'h0, sw0}, {8'h0, msw[0]});
            check("R2/R8 model sw dev1", {8'h0, sw1}, {8'h0, msw[1]});
            check("R4 model sdo dev0", {15'h0, sdo0}, {15'h0, mdo[0]});
            check("R4 model sdo dev1", {15'h0, sdo1}, {15'h0, mdo[1]});
            check("R9 model busy dev0", {15'h0, busy0}, {15'h0, mact[0] | mpd[0]});
            check("R9 model busy dev1", {15'h0, busy1}, {15'h0, mact[1] | mpd[1]});
        end
    end

    // ---------------- stimulus helpers ---------------------------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sclk = 1'b1; sdi = val[i]; tick(H);
            sclk = 1'b0; tick(H);
        end
    endtask

    task automatic write_word(input logic [15:0] val, input int n);
        frame_n = 1'b0; tick(4);
        send(val, n);
        frame_n = 1'b1; tick(GAP + 8);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R7: reset state
        check("R7 reset sw", {8'h0, sw0}, 16'h0000);
        check("R7 reset sdo", {15'h0, sdo0}, 16'h0000);
        check("R7 reset busy", {15'h0, busy0}, 16'h0000);

        // R1 R2 R5 R9: eight-bit write with exact transfer timing
        frame_n = 1'b0; tick(4);
        send(16'h00A5, 8);
        tick(4);
        check("R5 no transfer before frame rise", {8'h0, sw0}, 16'h0000);
        frame_n = 1'b1;
        tick(2);
        check("R9 busy still low after two edges", {15'h0, busy0}, 16'h0000);
        tick(1);
        check("R9 busy high on third edge", {15'h0, busy0}, 16'h0001);
        tick(GAP - 1);
        check("R8 closing lines wait the gap", {8'h0, sw0}, 16'h0000);
        tick(1);
        check("R1 R2 word applied after gap", {8'h0, sw0}, 16'h00A5);
        check("R9 busy low when applied", {15'h0, busy0}, 16'h0000);
        tick(8);

        // R8: 0x0F -> 0x3C, lines 2 and 3 stay closed
        write_word(16'h000F, 8);
        frame_n = 1'b0; tick(4);
        send(16'h003C, 8);
        frame_n = 1'b1;
        tick(3);
        check("R8 opening lines drop first", {8'h0, sw0}, 16'h000C);
        for (int c = 0; c < GAP + 4; c++) begin
            tick(1);
            check("R8 staying lines never open", {8'h0, sw0 & 8'h0C}, 16'h000C);
        end
        check("R8 final word", {8'h0, sw0}, 16'h003C);

        // R3: long and short writes
        write_word(16'h05A7, 12);
        check("R3 long write keeps last eight", {8'h0, sw0}, 16'h00A7);
        write_word(16'h0009, 4);
        check("R3 short write keeps older bits above", {8'h0, sw0}, 16'h0079);

        // R6: activity with frame high is ignored
        begin
            logic hold_sdo;
            hold_sdo = sdo0;
            for (int c = 0; c < 10; c++) begin
                sclk = 1'b1; sdi = 1'b1; tick(H);
                sclk = 1'b0; sdi = 1'b0; tick(H);
            end
            check("R6 sdo unchanged with frame high", {15'h0, sdo0}, {15'h0, hold_sdo});
            check("R6 sw unchanged with frame high", {8'h0, sw0}, 16'h0079);
            write_word(16'h0000, 0);
            check("R6 register untouched by idle clocks", {8'h0, sw0}, 16'h0079);
        end

        // R4: sixteen bits through the chain
        write_word(16'h4D81, 16);
        check("R4 chain near device", {8'h0, sw0}, 16'h0081);
        check("R4 chain far device", {8'h0, sw1}, 16'h004D);

        // R7: clear in the middle of a frame
        frame_n = 1'b0; tick(4);
        send(16'h0005, 3);
        clr_n = 1'b0; tick(4);
        check("R7 clear opens near switches", {8'h0, sw0}, 16'h0000);
        check("R7 clear opens far switches", {8'h0, sw1}, 16'h0000);
        check("R7 clear drops sdo", {15'h0, sdo0}, 16'h0000);
        clr_n = 1'b1; tick(4);
        frame_n = 1'b1; tick(GAP + 8);
        check("R7 register emptied by clear", {8'h0, sw0}, 16'h0000);

        // R10: a second frame rise during a running transfer
        frame_n = 1'b0; tick(4);
        send(16'h00C3, 8);
        frame_n = 1'b1; tick(3);
        frame_n = 1'b0; tick(3);
        send(16'h0002, 2);
        frame_n = 1'b1;
        begin
            bit saw_c3;
            saw_c3 = 1'b0;
            while (busy0) begin
                if (sw0 == 8'hC3) saw_c3 = 1'b1;
                check("R10 busy held across overlap", {15'h0, busy0}, 16'h0001);
                tick(1);
            end
            check("R10 first word completed", {15'h0, saw_c3}, 16'h0001);
        end
        check("R10 second word applied", {8'h0, sw0}, 16'h000E);
        tick(4);
        finish_run();
    end

endmodule